// File: doc/BRIEF.md
# AXI-Lite to Wishbone Bridge

This block sits between a processor's AXI4-Lite master port and a pipelined Wishbone bus. Each CPU load or store becomes exactly one Wishbone master cycle. The peripherals on that bus occupy a window that begins at a fixed base address, and the bridge sends on only the word offset inside that window. Data is 32 bits wide. The four AXI write strobes become the four Wishbone byte selects.

Only one transaction runs at any time. Address and write data go straight from the AXI inputs onto the Wishbone outputs, and read data goes straight from Wishbone back to AXI. No data is copied into holding registers. The AXI ready signals stay low until the Wishbone slave acknowledges, which keeps the master's address and data stable for the whole cycle. A cycle counter ends any Wishbone cycle that is never acknowledged and reports an error response, so the bus cannot hang.

Top module: `axil_wb_bridge`

## Requirements
- R1: While reset is held, wb_cyc, wb_stb, s_arready, s_rvalid, s_awready, s_wready and s_bvalid are all low.
- R2: A read starts from idle only when s_arvalid and s_rready are both high. The Wishbone read uses wb_we=0 and wb_adr=(s_araddr-BASE_ADDR)>>2. In the cycle where wb_ack=1 and wb_stall=0, s_arready and s_rvalid pulse high for one cycle, s_rdata equals wb_dat_i and s_rresp is 2'b00 (OKAY).
- R3: wb_cyc and wb_stb rise in the same cycle. wb_stb stays high while wb_stall is high and drops after the first cycle in which wb_stall is low. wb_cyc drops in the cycle after the accepted acknowledge.
- R4: A write starts when s_awvalid is high. No Wishbone cycle opens until s_wvalid is high. During the write, wb_we=1, wb_dat_o equals s_wdata, and wb_sel bit i equals s_wstrb bit i, which enables byte i (bits 8i+7:8i).
- R5: s_awready and s_wready pulse together in the acknowledge cycle. s_bvalid rises on the next cycle with s_bresp=2'b00 and stays high with a stable s_bresp until s_bready is seen. It is low in the cycle after that handshake.
- R6: If s_arvalid and s_awvalid are raised in the same idle cycle, the read is performed first and the write after it.
- R7: No new Wishbone cycle begins while a write response is waiting for s_bready.
- R8: If no acknowledge arrives within TIMEOUT cycles, the Wishbone cycle ends and the transaction completes with response 2'b10 (SLVERR) on s_rresp or s_bresp.
- R9: A cycle in which wb_ack and wb_stall are both high does not complete a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | AXI write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | DATA_W | AXI write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | AXI read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid (one-cycle pulse) |
| s_rready | input | 1 | Master able to take read data |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | WB_AW | Wishbone word address (offset into the window) |
| wb_sel | output | DATA_W/8 | Wishbone byte selects |
| wb_dat_o | output | DATA_W | Wishbone write data |
| wb_dat_i | input | DATA_W | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |
| wb_stall | input | 1 | Wishbone stall |

## Verification
The bench's slave model covers every combination of stall length (0, 1, 3) and acknowledge delay (0, 1, 2), including an acknowledge in the same cycle the request is taken. A bridge that held the strobe too long would issue a second request, and a bridge that dropped the cycle late would show wb_cyc still high after the acknowledge. One acknowledge is sent together with a stall and carries poisoned data. A bridge that completed on it would return the poison word instead of the stored value. Further tests cover simultaneous read and write requests, a write response held back while a read is waiting, write data that arrives late, partial strobes, and slaves that never answer. A wrong bridge would serve the write first, start a cycle during the pending response, open the cycle before the data exists, corrupt unselected bytes, or hang without returning SLVERR.

// File: rtl/axil_wb_bridge.sv
module axil_wb_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000,
  parameter int WB_AW = 30,
  parameter int TIMEOUT = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic                wb_cyc,
  output logic                wb_stb,
  output logic                wb_we,
  output logic [WB_AW-1:0]    wb_adr,
  output logic [DATA_W/8-1:0] wb_sel,
  output logic [DATA_W-1:0]   wb_dat_o,
  input  logic [DATA_W-1:0]   wb_dat_i,
  input  logic                wb_ack,
  input  logic                wb_stall
);

  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WDAT, S_WR, S_WRESP} state_t;

  state_t          st;
  logic            stb_q;
  logic            bvalid_q;
  logic [1:0]      bresp_q;
  logic [TW-1:0]   tcnt;
  logic            in_cyc, wb_ok, to_hit, fin;
  logic [1:0]      resp;
  logic [ADDR_W-1:0] cur_addr;

  assign in_cyc   = (st == S_RD) || (st == S_WR);
  assign wb_ok    = wb_ack && !wb_stall;
  assign to_hit   = tcnt == TW'(TIMEOUT - 1);
  assign fin      = in_cyc && (wb_ok || to_hit);
  assign resp     = wb_ok ? 2'b00 : 2'b10;
  assign cur_addr = (st == S_RD) ? s_araddr : s_awaddr;

  assign wb_cyc   = in_cyc;
  assign wb_stb   = stb_q;
  assign wb_we    = (st == S_WR);
  assign wb_adr   = WB_AW'((cur_addr - BASE_ADDR) >> 2);
  assign wb_sel   = s_wstrb;
  assign wb_dat_o = s_wdata;

  assign s_arready = (st == S_RD) && fin;
  assign s_rvalid  = (st == S_RD) && fin;
  assign s_rdata   = wb_dat_i;
  assign s_rresp   = resp;

  assign s_awready = (st == S_WR) && fin;
  assign s_wready  = (st == S_WR) && fin;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = bresp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      stb_q    <= 1'b0;
      tcnt     <= '0;
      bvalid_q <= 1'b0;
      bresp_q  <= 2'b00;
    end else begin
      if (in_cyc && !fin) tcnt <= tcnt + 1'b1;
      else                tcnt <= '0;

      if (stb_q && (!wb_stall || to_hit)) stb_q <= 1'b0;

      case (st)
        S_IDLE: begin
          if (s_arvalid && s_rready) begin
            st    <= S_RD;
            stb_q <= 1'b1;
          end else if (s_awvalid) begin
            st <= S_WDAT;
          end
        end
        S_WDAT: begin
          if (s_wvalid) begin
            st    <= S_WR;
            stb_q <= 1'b1;
          end
        end
        S_RD: if (fin) st <= S_IDLE;
        S_WR: begin
          if (fin) begin
            st       <= S_WRESP;
            bvalid_q <= 1'b1;
            bresp_q  <= resp;
          end
        end
        S_WRESP: begin
          if (s_bready) begin
            st       <= S_IDLE;
            bvalid_q <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axil_wb_bridge_chk.sv
module axil_wb_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wb_cyc,
  input logic       wb_stb,
  input logic       wb_we,
  input logic       wb_ack,
  input logic       wb_stall,
  input logic       s_arready,
  input logic       s_rvalid,
  input logic [1:0] s_rresp,
  input logic       s_awready,
  input logic       s_wready,
  input logic       s_bvalid,
  input logic       s_bready,
  input logic [1:0] s_bresp
);

  assert_stb_in_cyc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> wb_cyc);

  assert_stb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb && wb_stall |=> wb_stb || !wb_cyc);

  assert_stb_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb && !wb_stall |=> !wb_stb);

  assert_cyc_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && wb_ack && !wb_stall |=> !wb_cyc);

  assert_rvalid_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_arready && wb_cyc && !wb_we);

  assert_ok_needs_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && s_rresp == 2'b00 |-> wb_ack && !wb_stall);

  assert_aw_w_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_awready |-> s_wready && wb_we);

  assert_bvalid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));

  assert_bvalid_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && s_bready |=> !s_bvalid);

  assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_cyc && s_bvalid));

endmodule

bind axil_wb_bridge axil_wb_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
  .wb_ack(wb_ack), .wb_stall(wb_stall), .s_arready(s_arready),
  .s_rvalid(s_rvalid), .s_rresp(s_rresp), .s_awready(s_awready),
  .s_wready(s_wready), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_bresp(s_bresp)
);

// File: tb/axil_wb_bridge_tb.sv
`timescale 1ns/1ps
module axil_wb_bridge_tb;

  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] s_awaddr, s_wdata, s_araddr, s_rdata, wb_dat_o;
  logic [31:0] wb_dat_i;
  logic [3:0]  s_wstrb, wb_sel;
  logic        s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
  logic        s_arvalid, s_arready, s_rvalid, s_rready;
  logic [1:0]  s_bresp, s_rresp;
  logic        wb_cyc, wb_stb, wb_we, wb_ack, wb_stall;
  logic [29:0] wb_adr;

  always #2.5 clk = ~clk;

  axil_wb_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_sel(wb_sel), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_ack(wb_ack), .wb_stall(wb_stall)
  );

  typedef struct {bit we; logic [29:0] adr; logic [3:0] sel; logic [31:0] dat;} wb_item_t;
  typedef struct {bit is_rd; logic [31:0] dat; logic [1:0] resp;} rsp_t;

  wb_item_t exp_wb[$];
  string    wb_tag[$];
  rsp_t     exp_rsp[$];
  string    rsp_tag[$];

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [16];
  logic [31:0] ref_mem [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic int idx_of(input logic [31:0] a);
    logic [31:0] o;
    o = (a - BASE) >> 2;
    return int'(o[3:0]);
  endfunction

  // Wishbone slave model
  int stall_lat = 0, ack_lat = 0, phase = 0, cnt = 0, cur = 0;
  bit mute = 0, bogus = 0, bogus_done = 0;

  always @(negedge clk) begin
    wb_item_t e;
    string t;
    wb_ack = 1'b0;
    if (rst_n !== 1'b1 || wb_cyc !== 1'b1) begin
      phase = 0; cnt = 0; wb_stall = 1'b0; bogus_done = 0;
    end else begin
      case (phase)
        0: begin
          if (cnt < stall_lat) begin
            wb_stall = 1'b1; cnt++;
          end else begin
            wb_stall = 1'b0;
            chk(wb_stb, "R3", "strobe present at accept", 32'(wb_stb), 1);
            cur = int'(wb_adr[3:0]);
            if (exp_wb.size() == 0) chk(0, "R2", "unexpected wishbone request", 32'(wb_adr), 0);
            else begin
              e = exp_wb.pop_front(); t = wb_tag.pop_front();
              chk(wb_we == e.we, t, "wb_we", 32'(wb_we), 32'(e.we));
              chk(wb_adr == e.adr, t, "wb_adr offset", 32'(wb_adr), 32'(e.adr));
              if (e.we) begin
                chk(wb_sel == e.sel, t, "wb_sel", 32'(wb_sel), 32'(e.sel));
                chk(wb_dat_o == e.dat, t, "wb_dat_o", wb_dat_o, e.dat);
              end
            end
            if (wb_we)
              for (int b = 0; b < 4; b++) if (wb_sel[b]) mem[cur][8*b +: 8] = wb_dat_o[8*b +: 8];
            phase = 1; cnt = 0;
            if (ack_lat == 0 && !mute) begin
              wb_ack = 1'b1; wb_dat_i = mem[cur]; phase = 2;
            end
          end
        end
        1: begin
          chk(!wb_stb, "R3", "strobe dropped after accept", 32'(wb_stb), 0);
          cnt++;
          wb_stall = 1'b0;
          if (!mute && cnt >= ack_lat) begin
            if (bogus && !bogus_done) begin
              wb_stall = 1'b1; wb_ack = 1'b1; wb_dat_i = 32'hDEAD_BEEF; bogus_done = 1;
            end else begin
              wb_ack = 1'b1; wb_dat_i = mem[cur]; phase = 2;
            end
          end
        end
        default: chk(0, "R3", "cycle still open after ack", 1, 0);
      endcase
    end
  end

  // Response monitor
  always begin
    rsp_t r;
    string t;
    @(negedge clk);
    #2;
    if (rst_n === 1'b1 && s_rvalid && s_rready) begin
      if (exp_rsp.size() == 0) chk(0, "R2", "unexpected read response", s_rdata, 0);
      else begin
        r = exp_rsp.pop_front(); t = rsp_tag.pop_front();
        chk(r.is_rd, t, "response kind read", 1, 32'(r.is_rd));
        chk(s_rresp == r.resp, t, "rresp", 32'(s_rresp), 32'(r.resp));
        if (r.resp == 2'b00) chk(s_rdata == r.dat, t, "rdata", s_rdata, r.dat);
      end
    end
    if (rst_n === 1'b1 && s_bvalid && s_bready) begin
      if (exp_rsp.size() == 0) chk(0, "R5", "unexpected write response", 32'(s_bresp), 0);
      else begin
        r = exp_rsp.pop_front(); t = rsp_tag.pop_front();
        chk(!r.is_rd, t, "response kind write", 0, 32'(r.is_rd));
        chk(s_bresp == r.resp, t, "bresp", 32'(s_bresp), 32'(r.resp));
      end
    end
  end

  task automatic push_wb(input bit we, input logic [31:0] a, input logic [3:0] sel,
                         input logic [31:0] d, input string t);
    wb_item_t e;
    e.we = we; e.adr = 30'((a - BASE) >> 2); e.sel = sel; e.dat = d;
    exp_wb.push_back(e); wb_tag.push_back(t);
    if (we)
      for (int b = 0; b < 4; b++) if (sel[b]) ref_mem[idx_of(a)][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic push_rsp(input bit rd, input logic [31:0] d, input logic [1:0] resp, input string t);
    rsp_t r;
    r.is_rd = rd; r.dat = d; r.resp = resp;
    exp_rsp.push_back(r); rsp_tag.push_back(t);
  endtask

  task automatic axi_read(input logic [31:0] a, input logic [1:0] resp, input string t);
    push_wb(0, a, 4'h0, 0, t);
    push_rsp(1, ref_mem[idx_of(a)], resp, t);
    s_araddr = a; s_arvalid = 1'b1;
    do tick(); while (!s_arready);
    chk(s_rvalid, t, "rvalid with arready", 32'(s_rvalid), 1);
    tick();
    s_arvalid = 1'b0;
  endtask

  task automatic axi_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] sel,
                           input int wdly, input int bdly, input logic [1:0] resp, input string t);
    push_wb(1, a, sel, d, t);
    push_rsp(0, 0, resp, t);
    s_awaddr = a; s_wdata = d; s_wstrb = sel; s_awvalid = 1'b1;
    for (int k = 0; k < wdly; k++) begin
      tick();
      chk(!wb_cyc, "R4", "no cycle before write data", 32'(wb_cyc), 0);
    end
    s_wvalid = 1'b1;
    do tick(); while (!(s_awready || s_wready));
    chk(s_awready && s_wready, "R5", "awready and wready together", {s_awready, s_wready}, 2'b11);
    tick();
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    chk(s_bvalid, "R5", "bvalid after ack", 32'(s_bvalid), 1);
    for (int k = 0; k < bdly; k++) begin
      tick();
      chk(s_bvalid, "R5", "bvalid held", 32'(s_bvalid), 1);
    end
    s_bready = 1'b1;
    tick();
    s_bready = 1'b0;
    chk(!s_bvalid, "R5", "bvalid cleared after handshake", 32'(s_bvalid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
      ref_mem[i] = mem[i];
    end
    rst_n = 1'b0; wb_ack = 1'b0; wb_stall = 1'b0; wb_dat_i = '0;
    s_awaddr = '0; s_awvalid = 0; s_wdata = '0; s_wstrb = '0; s_wvalid = 0; s_bready = 0;
    s_araddr = '0; s_arvalid = 0; s_rready = 1;
    tick(); tick();
    s_arvalid = 1'b1; s_awvalid = 1'b1; s_wvalid = 1'b1;
    tick();
    chk(!wb_cyc && !wb_stb, "R1", "wishbone idle in reset", {wb_cyc, wb_stb}, 0);
    chk(!s_arready && !s_rvalid, "R1", "read side idle in reset", {s_arready, s_rvalid}, 0);
    chk(!s_awready && !s_wready && !s_bvalid, "R1", "write side idle in reset",
        {s_awready, s_wready, s_bvalid}, 0);
    s_arvalid = 0; s_awvalid = 0; s_wvalid = 0;
    rst_n = 1'b1;
    tick();

    // R2 reads across the window, R4 full writes, several latencies
    for (int sl = 0; sl < 3; sl++)
      for (int al = 0; al < 3; al++) begin
        stall_lat = (sl == 2) ? 3 : sl; ack_lat = al;
        axi_write(BASE + 32'(4 * (sl * 3 + al)), 32'h1234_0000 + 32'(sl * 16 + al), 4'hF, 0, 0, 2'b00, "R4");
        axi_read(BASE + 32'(4 * (sl * 3 + al)), 2'b00, "R2");
      end
    stall_lat = 1; ack_lat = 1;
    axi_read(BASE + 32'h3C, 2'b00, "R2");

    // R4 partial strobes and late write data; R5 held response
    axi_write(BASE + 32'h28, 32'hCAFE_F00D, 4'b0101, 3, 4, 2'b00, "R4");
    axi_read(BASE + 32'h28, 2'b00, "R4");
    axi_write(BASE + 32'h2C, 32'h8877_6655, 4'b1000, 1, 2, 2'b00, "R5");
    axi_read(BASE + 32'h2C, 2'b00, "R4");

    // R2 read waits for rready
    s_rready = 1'b0; s_araddr = BASE + 32'h30; s_arvalid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(!wb_cyc, "R2", "no read cycle while rready low", 32'(wb_cyc), 0);
    end
    s_arvalid = 1'b0; s_rready = 1'b1;
    axi_read(BASE + 32'h30, 2'b00, "R2");

    // R9 acknowledge together with stall is ignored
    stall_lat = 0; ack_lat = 1; bogus = 1;
    axi_read(BASE + 32'h08, 2'b00, "R9");
    bogus = 0;

    // R6 simultaneous read and write: read first
    push_wb(0, BASE + 32'h14, 4'h0, 0, "R6");
    push_rsp(1, ref_mem[5], 2'b00, "R6");
    push_wb(1, BASE + 32'h18, 4'hF, 32'h0BAD_CAFE, "R6");
    push_rsp(0, 0, 2'b00, "R6");
    s_araddr = BASE + 32'h14; s_arvalid = 1'b1;
    s_awaddr = BASE + 32'h18; s_wdata = 32'h0BAD_CAFE; s_wstrb = 4'hF;
    s_awvalid = 1'b1; s_wvalid = 1'b1;
    do tick(); while (!s_arready);
    chk(!s_awready, "R6", "write not served first", 32'(s_awready), 0);
    tick(); s_arvalid = 1'b0;
    do tick(); while (!s_awready);
    tick(); s_awvalid = 1'b0; s_wvalid = 1'b0;
    s_bready = 1'b1; tick(); s_bready = 1'b0;

    // R7 no cycle while write response pending
    push_wb(1, BASE + 32'h1C, 4'hF, 32'h7777_1111, "R7");
    push_rsp(0, 0, 2'b00, "R7");
    s_awaddr = BASE + 32'h1C; s_wdata = 32'h7777_1111; s_wstrb = 4'hF;
    s_awvalid = 1'b1; s_wvalid = 1'b1;
    do tick(); while (!s_awready);
    tick(); s_awvalid = 1'b0; s_wvalid = 1'b0;
    push_wb(0, BASE + 32'h1C, 4'h0, 0, "R7");
    push_rsp(1, ref_mem[7], 2'b00, "R7");
    s_araddr = BASE + 32'h1C; s_arvalid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(!wb_cyc && !s_arready, "R7", "no cycle during pending response", {wb_cyc, s_arready}, 0);
    end
    s_bready = 1'b1; tick(); s_bready = 1'b0;
    do tick(); while (!s_arready);
    tick(); s_arvalid = 1'b0;

    // R8 watchdog on a silent slave
    mute = 1;
    axi_read(BASE + 32'h20, 2'b10, "R8");
    axi_write(BASE + 32'h24, 32'h5555_AAAA, 4'hF, 0, 1, 2'b10, "R8");
    mute = 0;
    axi_read(BASE + 32'h24, 2'b00, "R8");

    repeat (4) tick();
    chk(exp_wb.size() == 0, "R2", "all wishbone requests seen", 32'(exp_wb.size()), 0);
    chk(exp_rsp.size() == 0, "R2", "all responses seen", 32'(exp_rsp.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule